// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter With Chainable Carry and Borrow

This block is a reversible binary counter that runs entirely on one system clock. Counting is driven by two separate strobe inputs instead of a direction bit. A rising edge on the up strobe adds one, provided the down strobe is high at that moment. A rising edge on the down strobe subtracts one, provided the up strobe is high. Both strobes, the clear and the preset are brought into the clock domain through a chain of flip-flops. Edges are detected on the synchronised levels.

An active-high clear forces the count to zero and beats every other input. An active-low preset copies the data input into the count for as long as it is held. The active-low carry output follows the synchronised up strobe while the count is at its maximum. The active-low borrow output follows the synchronised down strobe while the count is zero. Because of this, wiring one stage's carry and borrow to the next stage's up and down strobes builds a wider counter. An illegal strobe pattern leaves the count unchanged and sets a sticky fault flag, which only a clear removes.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on the up strobe while the down strobe is high increments the count by one.
- R2: A rising edge on the down strobe while the up strobe is high decrements the count by one.
- R3: Counting up from the all-ones value gives 0, and counting down from 0 gives the all-ones value (15 for the default width of 4).
- R4: After system reset the count is 0, carry_n and borrow_n are 1 and fault is 0. A high clear forces the count to 0 and fault to 0, with priority over preset, data and both strobes.
- R5: While preset_n is low and clear is low, the count follows data_i, including changes to data_i, and strobe edges have no effect.
- R6: carry_n is 0 exactly when the count is all ones and the synchronised up strobe is low; otherwise it is 1.
- R7: borrow_n is 0 exactly when the count is 0 and the synchronised down strobe is low; otherwise it is 1.
- R8: If a strobe is low during and after a clear or preset, its first rising edge after release is counted.
- R9: A rising edge on one strobe while the other strobe is low, or rising edges on both strobes in the same cycle, leave the count unchanged and set fault. Fault stays 1 until a clear.
- R10: A count change appears on the third rising clock edge after a strobe rises, with two synchroniser stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clear_i | input | 1 | Active-high clear of count and fault |
| preset_n_i | input | 1 | Active-low level-sensitive preset from data_i |
| data_i | input | WIDTH | Preset value |
| up_stb_i | input | 1 | Count-up strobe, counts on its rising edge |
| dn_stb_i | input | 1 | Count-down strobe, counts on its rising edge |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low carry, mirrors the up strobe at all ones |
| borrow_n_o | output | 1 | Active-low borrow, mirrors the down strobe at zero |
| fault_o | output | 1 | Sticky flag for illegal strobe patterns |

## Verification
A wrong edge-detector history would show up as a missing or doubled step in count_o. It would appear on the third clock edge after the strobe rises, so every strobe pulse is followed by a check of the count. A wrong terminal-state compare would misplace the carry_n or borrow_n low phase. This is checked both at the ports and through a chained pair of stages, where the error would show as a wrong upper nibble some eight cycles later. The sticky fault bit is checked right after the illegal pattern and again after a later legal step, so that a bit which clears itself would be caught.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned CTL_CLR = 0;
  localparam int unsigned CTL_PRE = 1;
  localparam int unsigned CTL_DN  = 2;
  localparam int unsigned CTL_UP  = 3;
  localparam int unsigned CTL_W   = 4;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4,
    OP_FAULT = 3'd5
  } count_op_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= RESET_VAL;
      end
    end else begin
      stg_q <= stg_d;
    end
  end

  assign sync_o = stg_q[LAST];
endmodule

// File: rtl/updn_edge_decode.sv
module updn_edge_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic up_lvl,
  input  logic dn_lvl,
  output logic step_up,
  output logic step_dn,
  output logic conflict
);
  logic up_prev_q, dn_prev_q;
  logic up_rise, dn_rise;

  always_comb begin
    up_rise  = up_lvl & ~up_prev_q;
    dn_rise  = dn_lvl & ~dn_prev_q;
    conflict = (up_rise & dn_rise) | (up_rise & ~dn_lvl) | (dn_rise & ~up_lvl);
    step_up  = up_rise & dn_lvl & ~dn_rise;
    step_dn  = dn_rise & up_lvl & ~up_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev_q <= 1'b1;
      dn_prev_q <= 1'b1;
    end else begin
      up_prev_q <= up_lvl;
      dn_prev_q <= dn_lvl;
    end
  end

  // R9: never both directions, and no step when a conflict is flagged
  p_one_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, conflict}));
  // R1: an up step only follows a low-to-high change of the up level
  p_up_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> (up_lvl && !up_prev_q && dn_lvl));
  // R2: a down step only follows a low-to-high change of the down level
  p_dn_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> (dn_lvl && !dn_prev_q && up_lvl));
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pre,
  input  logic [WIDTH-1:0] data,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             conflict,
  output logic [WIDTH-1:0] count,
  output logic             fault
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  count_op_e        op;
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             flt_q, flt_d;
  logic             cnt_en, flt_en;

  always_comb begin
    if (clr)           op = OP_CLEAR;
    else if (pre)      op = OP_LOAD;
    else if (conflict) op = OP_FAULT;
    else if (step_up)  op = OP_INC;
    else if (step_dn)  op = OP_DEC;
    else               op = OP_HOLD;
  end

  always_comb begin
    cnt_d  = cnt_q;
    flt_d  = flt_q;
    cnt_en = 1'b0;
    flt_en = 1'b0;
    case (op)
      OP_CLEAR: begin cnt_d = '0; cnt_en = 1'b1; flt_d = 1'b0; flt_en = 1'b1; end
      OP_LOAD:  begin cnt_d = data; cnt_en = 1'b1; end
      OP_FAULT: begin flt_d = 1'b1; flt_en = 1'b1; end
      OP_INC:   begin cnt_d = cnt_q + ONE; cnt_en = 1'b1; end
      OP_DEC:   begin cnt_d = cnt_q - ONE; cnt_en = 1'b1; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
    end else if (flt_en) begin
      flt_q <= flt_d;
    end
  end

  assign count = cnt_q;
  assign fault = flt_q;

  // R4: clear zeroes count and fault on the next edge
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !fault));
  // R5: preset copies the data seen at the edge
  p_preset_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pre) |=> (count == $past(data)));
  // R9: conflicting strobes hold the count and raise fault
  p_conflict_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pre && conflict) |=> ($stable(count) && fault));
  // R9: fault is sticky until clear
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault);
  // R1/R3: an up step adds one, modulo the width
  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pre && step_up) |=> (count == $past(count) + ONE));
  // R2/R3: a down step subtracts one, modulo the width
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pre && step_dn) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/updn_term_gen.sv
module updn_term_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_top, at_bot;

  always_comb begin
    at_top   = (count == TOP);
    at_bot   = (count == BOT);
    carry_n  = ~(at_top & ~up_lvl);
    borrow_n = ~(at_bot & ~dn_lvl);
  end

  // R6: carry never asserted away from the all-ones state
  p_carry_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (count == TOP));
  // R7: borrow never asserted away from zero
  p_borrow_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (count == BOT));
  // R6/R7: carry and borrow never low together
  p_term_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_n || borrow_n));
endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             preset_n_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_stb_i,
  input  logic             dn_stb_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o,
  output logic             fault_o
);
  localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'((1 << CTL_UP) | (1 << CTL_DN) | (1 << CTL_PRE));

  logic [CTL_W-1:0] ctl_raw, ctl_sync;
  logic             step_up, step_dn, conflict;
  logic [WIDTH-1:0] count;

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[CTL_CLR] = clear_i;
    ctl_raw[CTL_PRE] = preset_n_i;
    ctl_raw[CTL_DN]  = dn_stb_i;
    ctl_raw[CTL_UP]  = up_stb_i;
  end

  updn_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ctl_raw), .sync_o(ctl_sync)
  );

  updn_edge_decode u_edge (
    .clk(clk), .rst_n(rst_n),
    .up_lvl(ctl_sync[CTL_UP]), .dn_lvl(ctl_sync[CTL_DN]),
    .step_up(step_up), .step_dn(step_dn), .conflict(conflict)
  );

  updn_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n),
    .clr(ctl_sync[CTL_CLR]), .pre(~ctl_sync[CTL_PRE]), .data(data_i),
    .step_up(step_up), .step_dn(step_dn), .conflict(conflict),
    .count(count), .fault(fault_o)
  );

  updn_term_gen #(.WIDTH(WIDTH)) u_term (
    .clk(clk), .rst_n(rst_n), .count(count),
    .up_lvl(ctl_sync[CTL_UP]), .dn_lvl(ctl_sync[CTL_DN]),
    .carry_n(carry_n_o), .borrow_n(borrow_n_o)
  );

  assign count_o = count;
endmodule

// File: tb/sim_updn_strobe_counter.sv
module sim_updn_strobe_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, pre_n = 1'b1, up = 1'b1, dn = 1'b1;
  logic [W-1:0] data = '0;
  logic [W-1:0] cnt;
  logic carry_n, borrow_n, fault;

  logic c_clr = 1'b0, c_pre_n = 1'b1, c_up = 1'b1, c_dn = 1'b1;
  logic [7:0] c_data = '0;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic lo_cy, lo_bw, hi_cy, hi_bw, lo_f, hi_f;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  updn_strobe_counter u0 (
    .clk(clk), .rst_n(rst_n), .clear_i(clr), .preset_n_i(pre_n), .data_i(data),
    .up_stb_i(up), .dn_stb_i(dn), .count_o(cnt), .carry_n_o(carry_n),
    .borrow_n_o(borrow_n), .fault_o(fault)
  );

  updn_strobe_counter u_lo (
    .clk(clk), .rst_n(rst_n), .clear_i(c_clr), .preset_n_i(c_pre_n), .data_i(c_data[3:0]),
    .up_stb_i(c_up), .dn_stb_i(c_dn), .count_o(lo_cnt), .carry_n_o(lo_cy),
    .borrow_n_o(lo_bw), .fault_o(lo_f)
  );

  updn_strobe_counter u_hi (
    .clk(clk), .rst_n(rst_n), .clear_i(c_clr), .preset_n_i(c_pre_n), .data_i(c_data[7:4]),
    .up_stb_i(lo_cy), .dn_stb_i(lo_bw), .count_o(hi_cnt), .carry_n_o(hi_cy),
    .borrow_n_o(hi_bw), .fault_o(hi_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1; wait_n(4); clr = 1'b0; wait_n(4);
  endtask

  task automatic do_preset(input logic [W-1:0] v);
    @(negedge clk); data = v; pre_n = 1'b0; wait_n(4); pre_n = 1'b1; wait_n(4);
  endtask

  task automatic pulse_up();
    @(negedge clk); up = 1'b0; wait_n(4); up = 1'b1; wait_n(4);
  endtask

  task automatic pulse_dn();
    @(negedge clk); dn = 1'b0; wait_n(4); dn = 1'b1; wait_n(4);
  endtask

  task automatic t_reset();
    chk("R4 reset count", cnt, 0);
    chk("R4 reset carry_n", carry_n, 1);
    chk("R4 reset borrow_n", borrow_n, 1);
    chk("R4 reset fault", fault, 0);
  endtask

  task automatic t_sequence();
    do_clear();
    chk("R4 clear", cnt, 0);
    do_preset(4'd13);
    chk("R5 preset 13", cnt, 13);
    pulse_up(); chk("R1 up to 14", cnt, 14);
    pulse_up(); chk("R1 up to 15", cnt, 15);
    chk("R6 carry high while strobe high", carry_n, 1);
    @(negedge clk); up = 1'b0; wait_n(4);
    chk("R6 carry low at 15", carry_n, 0);
    chk("R7 borrow high at 15", borrow_n, 1);
    up = 1'b1; wait_n(4);
    chk("R3 wrap up to 0", cnt, 0);
    chk("R6 carry released", carry_n, 1);
    pulse_up(); chk("R1 up to 1", cnt, 1);
    pulse_up(); chk("R1 up to 2", cnt, 2);
    pulse_dn(); chk("R2 down to 1", cnt, 1);
    pulse_dn(); chk("R2 down to 0", cnt, 0);
    @(negedge clk); dn = 1'b0; wait_n(4);
    chk("R7 borrow low at 0", borrow_n, 0);
    chk("R6 carry high at 0", carry_n, 1);
    dn = 1'b1; wait_n(4);
    chk("R3 wrap down to 15", cnt, 15);
    chk("R7 borrow released", borrow_n, 1);
  endtask

  task automatic t_latency();
    do_preset(4'd6);
    @(negedge clk); up = 1'b0; wait_n(4);
    up = 1'b1;
    wait_n(2); chk("R10 no change after two edges", cnt, 6);
    wait_n(1); chk("R10 change on third edge", cnt, 7);
    wait_n(3);
  endtask

  task automatic t_preset();
    @(negedge clk); data = 4'd3; pre_n = 1'b0; wait_n(4);
    chk("R5 preset tracks 3", cnt, 3);
    data = 4'd10; wait_n(4);
    chk("R5 preset tracks 10", cnt, 10);
    up = 1'b0; wait_n(4); up = 1'b1; wait_n(4);
    chk("R5 strobe ignored during preset", cnt, 10);
    clr = 1'b1; wait_n(4);
    chk("R4 clear beats preset", cnt, 0);
    clr = 1'b0; wait_n(4);
    chk("R5 preset after clear", cnt, 10);
    pre_n = 1'b1; wait_n(4);
    chk("R5 hold after release", cnt, 10);
  endtask

  task automatic t_release();
    @(negedge clk); up = 1'b0; wait_n(4);
    do_clear();
    chk("R4 clear with strobe low", cnt, 0);
    up = 1'b1; wait_n(4);
    chk("R8 edge after clear counts", cnt, 1);
    @(negedge clk); dn = 1'b0; wait_n(4);
    do_preset(4'd9);
    dn = 1'b1; wait_n(4);
    chk("R8 edge after preset counts", cnt, 8);
  endtask

  task automatic t_fault();
    do_preset(4'd5);
    @(negedge clk); dn = 1'b0; wait_n(4);
    up = 1'b0; wait_n(4); up = 1'b1; wait_n(4);
    chk("R9 count held on conflict", cnt, 5);
    chk("R9 fault set", fault, 1);
    dn = 1'b1; wait_n(4);
    chk("R2 legal step after conflict", cnt, 4);
    chk("R9 fault sticky", fault, 1);
    do_clear();
    chk("R4 clear drops fault", fault, 0);
    do_preset(4'd7);
    @(negedge clk); up = 1'b0; dn = 1'b0; wait_n(4);
    up = 1'b1; dn = 1'b1; wait_n(4);
    chk("R9 simultaneous edges hold", cnt, 7);
    chk("R9 simultaneous edges fault", fault, 1);
    do_clear();
  endtask

  task automatic c_pulse(input bit go_up);
    @(negedge clk);
    if (go_up) c_up = 1'b0; else c_dn = 1'b0;
    wait_n(4);
    c_up = 1'b1; c_dn = 1'b1;
    wait_n(8);
  endtask

  task automatic t_chain();
    @(negedge clk); c_data = 8'h2E; c_pre_n = 1'b0; wait_n(4); c_pre_n = 1'b1; wait_n(8);
    chk("R5 chain preset", {hi_cnt, lo_cnt}, 8'h2E);
    for (int i = 0; i < 3; i++) c_pulse(1'b1);
    chk("R6 chain carry up", {hi_cnt, lo_cnt}, 8'h31);
    for (int i = 0; i < 3; i++) c_pulse(1'b0);
    chk("R7 chain borrow down", {hi_cnt, lo_cnt}, 8'h2E);
    @(negedge clk); c_data = 8'h00; c_pre_n = 1'b0; wait_n(4); c_pre_n = 1'b1; wait_n(8);
    c_pulse(1'b0);
    chk("R3 chain wrap down", {hi_cnt, lo_cnt}, 8'hFF);
    c_pulse(1'b1);
    chk("R3 chain wrap up", {hi_cnt, lo_cnt}, 8'h00);
    chk("R9 chain no fault", {hi_f, lo_f}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_sequence();
    t_latency();
    t_preset();
    t_release();
    t_fault();
    t_chain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule